// File: doc/BRIEF.md
# Burst-Mode APC Comparator Scheduler

This block shares one external comparator between the automatic power control (APC) integrator of a burst-mode laser transmitter and three quick-trip checks: high transmit power, low transmit power and high bias. A rising edge on the burst enable starts a sample timer. A 4-bit rate code selects the delay to the first sample and the period of the samples after it. Each sample tick consumes one slot of a repeating eight-slot schedule. The block presents the reference to use for that slot on `ref_sel`, reads the comparator answer on `cmp_in`, and updates either the 13-bit bias DAC code or one alarm flag.

The bias code starts from a temperature-indexed lookup value that the block receives on its input. APC slots move the code by one LSB. The code is always held at or below a programmable maximum. When the enable pulses are too short for any sample to land, the block stops integrating and follows the lookup value instead. In open-loop mode the lookup value drives the code directly. The surrounding chip provides the comparator, the DAC and the lookup memory. Timing in nanoseconds is turned into clock cycles through a clock-period parameter, which defaults to 50 ns.

Top module: `apc_cmp_scheduler`

## Requirements
- R1: After a rising edge of `ben`, the first sample is taken F clock edges after the edge that first sees `ben` high. F = ceil(t_first / CLK_NS), where t_first in ns for codes 0..9 is 350, 550, 750, 950, 1350, 1550, 1750, 2150, 2950, 3150. Codes 10 to 15 behave as code 9.
- R2: After the first sample, samples repeat every R edges while `ben` stays high. R = ceil(t_rep / CLK_NS), where t_rep in ns for codes 0..9 is 800, 1200, 1600, 2000, 2800, 3200, 3600, 4400, 6000, 6400. A fall of `ben` cancels any pending sample, and no sample is taken while `ben` is low.
- R3: Slots are numbered 0 to 7 from each rise of `ben` and wrap after 7. Slots 0-5 use `ref_sel`=0 (APC set point). Slot 6 uses `ref_sel`=1 (high-power threshold) if the latest APC answer was 1, and `ref_sel`=2 (low-power threshold) otherwise. Slot 7 uses `ref_sel`=3 (bias reference).
- R4: In closed-loop mode, an APC sample with `cmp_in`=1 (power above set point) lowers the bias code by 1, stopping at 0. An APC sample with `cmp_in`=0 raises it by 1.
- R5: `txp_hi_alarm` takes `cmp_in` at a slot-6 sample with `ref_sel`=1. `txp_lo_alarm` takes the inverse of `cmp_in` at a slot-6 sample with `ref_sel`=2. Each alarm otherwise holds its value, so neither changes while `ben` is low.
- R6: `bias_hi_alarm` takes `cmp_in` at each slot-7 sample and holds its value otherwise.
- R7: A burst that ends without any sample is short. After 32 consecutive short bursts, the integrator is suspended and the bias code follows the shifted lookup value every cycle. The first sample of any later burst lifts the suspension and applies its APC step in the same cycle.
- R8: The bias code never exceeds the previous cycle's `max_bias`. A raise at the limit stays at the limit, and a lowered limit clamps the code. `bias_max_flag` is 1 exactly when the code equals the previous cycle's `max_bias`.
- R9: In closed-loop mode, the lookup value is loaded once in the first cycle after reset and every cycle while suspended. A load whose shifted value exceeds `max_bias` is skipped, and the code keeps its previous value.
- R10: With `open_loop`=1, the code is the shifted lookup value clamped to `max_bias`, and APC samples do not step it. The shift puts the lookup byte in bits 12:5 when `lut_msb_align`=1 and in bits 11:4 when `lut_msb_align`=0.
- R11: While `rst` is high, `bias_code`, all alarms, `bias_max_flag` and `ref_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ben | input | 1 | Burst enable |
| rate_code | input | 4 | Sample timing code |
| cmp_in | input | 1 | Comparator answer, 1 = input above selected reference |
| open_loop | input | 1 | Lookup value drives the bias code directly |
| lut_msb_align | input | 1 | Lookup placement: 1 = bits 12:5, 0 = bits 11:4 |
| lut_bias | input | 8 | Temperature-indexed lookup bias value |
| max_bias | input | 13 | Bias code ceiling |
| bias_code | output | 13 | Bias DAC code |
| ref_sel | output | 2 | Comparator reference select |
| txp_hi_alarm | output | 1 | High transmit power quick trip |
| txp_lo_alarm | output | 1 | Low transmit power quick trip |
| bias_hi_alarm | output | 1 | High bias quick trip |
| bias_max_flag | output | 1 | Bias code at ceiling |

## Verification
Two events can land on the same clock edge: the sample that ends a suspension, and the first integrator step. The bench provokes this by sending 32 enable pulses, each too short for a sample. It then changes the lookup value while the block is suspended, and finally sends a long burst with the comparator answering "below set point". The result is judged correct only if the code right after the first sample equals the last shifted lookup value plus one. A second overlap is the clamp and the step: a raise that reaches `max_bias` must stop there with the flag set on that same edge.

// File: rtl/apc_sched_pkg.sv
package apc_sched_pkg;

  typedef enum logic [1:0] {
    REF_SETPT   = 2'd0,
    REF_TXP_HI  = 2'd1,
    REF_TXP_LO  = 2'd2,
    REF_BIAS_HI = 2'd3
  } ref_sel_e;

  localparam int RATE_CODES = 10;
  localparam int APC_SLOTS  = 6;
  localparam int TXP_SLOT   = 6;
  localparam int CYCLE_LEN  = 8;

  function automatic int first_ns(input int code);
    case (code)
      0: return 350;
      1: return 550;
      2: return 750;
      3: return 950;
      4: return 1350;
      5: return 1550;
      6: return 1750;
      7: return 2150;
      8: return 2950;
      default: return 3150;
    endcase
  endfunction

  function automatic int rep_ns(input int code);
    case (code)
      0: return 800;
      1: return 1200;
      2: return 1600;
      3: return 2000;
      4: return 2800;
      5: return 3200;
      6: return 3600;
      7: return 4400;
      8: return 6000;
      default: return 6400;
    endcase
  endfunction

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/apc_sample_timer.sv
module apc_sample_timer
  import apc_sched_pkg::*;
#(
  parameter int CLK_NS = 50,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ben,
  input  logic [CODE_W-1:0] rate_code,
  output logic              burst_rise,
  output logic              burst_fall,
  output logic              sample_tick
);
  localparam int MAX_CYC = ns_to_cyc(rep_ns(RATE_CODES - 1), CLK_NS);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int IDX_W   = $clog2(RATE_CODES);

  logic [CNT_W-1:0] first_tab [RATE_CODES];
  logic [CNT_W-1:0] rep_tab   [RATE_CODES];
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic             ben_q;
  logic             active;

  for (genvar g = 0; g < RATE_CODES; g++) begin : g_rate
    assign first_tab[g] = CNT_W'(ns_to_cyc(first_ns(g), CLK_NS) - 1);
    assign rep_tab[g]   = CNT_W'(ns_to_cyc(rep_ns(g), CLK_NS) - 1);
  end

  always_comb begin
    if (int'(rate_code) >= RATE_CODES) idx = IDX_W'(RATE_CODES - 1);
    else                               idx = IDX_W'(rate_code);
  end

  assign burst_rise  = ben & ~ben_q;
  assign burst_fall  = ~ben & ben_q;
  assign sample_tick = active & ben & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ben_q  <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      ben_q <= ben;
      if (burst_rise) begin
        active <= 1'b1;
        cnt    <= first_tab[idx];
      end else if (!ben) begin
        active <= 1'b0;
      end else if (active) begin
        if (cnt == '0) cnt <= rep_tab[idx];
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  // R1: a sample never follows directly on the enable edge
  p_no_early_sample_r1: assert property (@(posedge clk) disable iff (rst)
    burst_rise |=> !sample_tick);

  // R2: a dropped enable leaves no pending sample for the next cycle
  p_abort_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    burst_fall |=> !sample_tick);

endmodule

// File: rtl/apc_burst_qual.sv
module apc_burst_qual #(
  parameter int SHORT_LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_rise,
  input  logic burst_fall,
  input  logic sample_tick,
  output logic suspended
);
  localparam int SC_W = $clog2(SHORT_LIMIT + 1);

  logic [SC_W-1:0] short_cnt;
  logic            seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      short_cnt <= '0;
      suspended <= 1'b0;
      seen      <= 1'b0;
    end else begin
      if (burst_rise)       seen <= 1'b0;
      else if (sample_tick) seen <= 1'b1;

      if (sample_tick) begin
        short_cnt <= '0;
        suspended <= 1'b0;
      end else if (burst_fall && !seen) begin
        if (short_cnt != SC_W'(SHORT_LIMIT)) short_cnt <= short_cnt + 1'b1;
        if (short_cnt == SC_W'(SHORT_LIMIT - 1)) suspended <= 1'b1;
      end
    end
  end

  // R7: suspension only exists with a full run of short bursts recorded
  p_suspend_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
    suspended |-> (short_cnt == SC_W'(SHORT_LIMIT)));

  // R7: any sample lifts the suspension
  p_sample_resumes_r7: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !suspended);

endmodule

// File: rtl/apc_slot_alarms.sv
module apc_slot_alarms
  import apc_sched_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ben,
  input  logic     burst_rise,
  input  logic     sample_tick,
  input  logic     cmp_in,
  output ref_sel_e ref_sel,
  output logic     apc_tick,
  output logic     txp_hi,
  output logic     txp_lo,
  output logic     bias_hi
);
  localparam int SLOT_W = $clog2(CYCLE_LEN);

  logic [SLOT_W-1:0] slot;
  logic              last_above;

  always_comb begin
    if (int'(slot) < APC_SLOTS)      ref_sel = REF_SETPT;
    else if (int'(slot) == TXP_SLOT) ref_sel = last_above ? REF_TXP_HI : REF_TXP_LO;
    else                             ref_sel = REF_BIAS_HI;
  end

  assign apc_tick = sample_tick && (ref_sel == REF_SETPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot       <= '0;
      last_above <= 1'b0;
      txp_hi     <= 1'b0;
      txp_lo     <= 1'b0;
      bias_hi    <= 1'b0;
    end else begin
      if (burst_rise) slot <= '0;
      else if (sample_tick) begin
        if (int'(slot) == CYCLE_LEN - 1) slot <= '0;
        else                             slot <= slot + 1'b1;
      end
      if (sample_tick) begin
        case (ref_sel)
          REF_SETPT:   last_above <= cmp_in;
          REF_TXP_HI:  txp_hi     <= cmp_in;
          REF_TXP_LO:  txp_lo     <= ~cmp_in;
          REF_BIAS_HI: bias_hi    <= cmp_in;
          default:     ;
        endcase
      end
    end
  end

  // R5: power alarms frozen while the enable is low
  p_txp_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ben |=> $stable({txp_hi, txp_lo}));

  // R6: bias alarm moves only on its own slot
  p_bias_alarm_slot_r6: assert property (@(posedge clk) disable iff (rst)
    !(sample_tick && ref_sel == REF_BIAS_HI) |=> $stable(bias_hi));

endmodule

// File: rtl/apc_bias_integ.sv
module apc_bias_integ #(
  parameter int DAC_W = 13,
  parameter int LUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_loop,
  input  logic             lut_msb_align,
  input  logic [LUT_W-1:0] lut_bias,
  input  logic [DAC_W-1:0] max_bias,
  input  logic             apc_tick,
  input  logic             cmp_in,
  input  logic             suspended,
  output logic [DAC_W-1:0] bias_code,
  output logic             bias_max_flag
);
  localparam int SHIFT_HI = DAC_W - LUT_W;
  localparam int SHIFT_LO = SHIFT_HI - 1;

  logic [DAC_W-1:0] lut_ext;
  logic [DAC_W-1:0] lut_shifted;
  logic [DAC_W-1:0] bias_next;
  logic             init_pend;

  assign lut_ext     = DAC_W'(lut_bias);
  assign lut_shifted = lut_msb_align ? (lut_ext << SHIFT_HI) : (lut_ext << SHIFT_LO);

  always_comb begin
    bias_next = bias_code;
    if (open_loop) begin
      bias_next = (lut_shifted > max_bias) ? max_bias : lut_shifted;
    end else if (apc_tick) begin
      if (cmp_in) bias_next = (bias_code == '0) ? '0 : bias_code - 1'b1;
      else        bias_next = (bias_code >= max_bias) ? max_bias : bias_code + 1'b1;
    end else if ((init_pend || suspended) && (lut_shifted <= max_bias)) begin
      bias_next = lut_shifted;
    end
    if (bias_next > max_bias) bias_next = max_bias;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bias_code     <= '0;
      bias_max_flag <= 1'b0;
      init_pend     <= 1'b1;
    end else begin
      bias_code     <= bias_next;
      bias_max_flag <= (bias_next == max_bias);
      init_pend     <= 1'b0;
    end
  end

  // R8: ceiling honoured one cycle after any limit value
  p_bias_ceiling_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> bias_code <= $past(max_bias));

  // R4: a closed-loop APC sample below the ceiling moves by one LSB
  p_single_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (apc_tick && !open_loop && bias_code < max_bias) |=>
      (bias_code == $past(bias_code) + 1'b1) ||
      (bias_code + 1'b1 == $past(bias_code)) ||
      (bias_code == '0 && $past(bias_code) == '0));

  // R9: an oversize recall while suspended leaves the code alone
  p_skip_recall_r9: assert property (@(posedge clk) disable iff (rst)
    (!open_loop && !apc_tick && suspended && lut_shifted > max_bias &&
     bias_code <= max_bias) |=> $stable(bias_code));

endmodule

// File: rtl/apc_cmp_scheduler.sv
module apc_cmp_scheduler
  import apc_sched_pkg::*;
#(
  parameter int CLK_NS      = 50,
  parameter int CODE_W      = 4,
  parameter int DAC_W       = 13,
  parameter int LUT_W       = 8,
  parameter int SHORT_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ben,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              cmp_in,
  input  logic              open_loop,
  input  logic              lut_msb_align,
  input  logic [LUT_W-1:0]  lut_bias,
  input  logic [DAC_W-1:0]  max_bias,
  output logic [DAC_W-1:0]  bias_code,
  output logic [1:0]        ref_sel,
  output logic              txp_hi_alarm,
  output logic              txp_lo_alarm,
  output logic              bias_hi_alarm,
  output logic              bias_max_flag
);
  logic     burst_rise;
  logic     burst_fall;
  logic     sample_tick;
  logic     suspended;
  logic     apc_tick;
  ref_sel_e ref_sel_w;

  apc_sample_timer #(.CLK_NS(CLK_NS), .CODE_W(CODE_W)) timer_i (
    .clk         (clk),
    .rst         (rst),
    .ben         (ben),
    .rate_code   (rate_code),
    .burst_rise  (burst_rise),
    .burst_fall  (burst_fall),
    .sample_tick (sample_tick)
  );

  apc_burst_qual #(.SHORT_LIMIT(SHORT_LIMIT)) qual_i (
    .clk         (clk),
    .rst         (rst),
    .burst_rise  (burst_rise),
    .burst_fall  (burst_fall),
    .sample_tick (sample_tick),
    .suspended   (suspended)
  );

  apc_slot_alarms slots_i (
    .clk         (clk),
    .rst         (rst),
    .ben         (ben),
    .burst_rise  (burst_rise),
    .sample_tick (sample_tick),
    .cmp_in      (cmp_in),
    .ref_sel     (ref_sel_w),
    .apc_tick    (apc_tick),
    .txp_hi      (txp_hi_alarm),
    .txp_lo      (txp_lo_alarm),
    .bias_hi     (bias_hi_alarm)
  );

  apc_bias_integ #(.DAC_W(DAC_W), .LUT_W(LUT_W)) integ_i (
    .clk           (clk),
    .rst           (rst),
    .open_loop     (open_loop),
    .lut_msb_align (lut_msb_align),
    .lut_bias      (lut_bias),
    .max_bias      (max_bias),
    .apc_tick      (apc_tick),
    .cmp_in        (cmp_in),
    .suspended     (suspended),
    .bias_code     (bias_code),
    .bias_max_flag (bias_max_flag)
  );

  assign ref_sel = ref_sel_w;

endmodule

// File: tb/apc_cmp_scheduler_tb_top.sv
module apc_cmp_scheduler_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ben = 1'b0;
  logic [3:0]  rate_code = '0;
  logic        cmp_in;
  logic        open_loop = 1'b0;
  logic        lut_msb_align = 1'b0;
  logic [7:0]  lut_bias = 8'd20;
  logic [12:0] max_bias = 13'd8191;
  logic [12:0] bias_code;
  logic [1:0]  ref_sel;
  logic        txp_hi_alarm, txp_lo_alarm, bias_hi_alarm, bias_max_flag;

  // comparator model: answer 1 means the monitored level is above the chosen reference
  logic m_sp = 1'b0, m_hi = 1'b0, m_lo = 1'b1, m_bh = 1'b0;
  assign cmp_in = (ref_sel == 2'd0) ? m_sp : (ref_sel == 2'd1) ? m_hi :
                  (ref_sel == 2'd2) ? m_lo : m_bh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  apc_cmp_scheduler dut_i (
    .clk(clk), .rst(rst), .ben(ben), .rate_code(rate_code), .cmp_in(cmp_in),
    .open_loop(open_loop), .lut_msb_align(lut_msb_align), .lut_bias(lut_bias),
    .max_bias(max_bias), .bias_code(bias_code), .ref_sel(ref_sel),
    .txp_hi_alarm(txp_hi_alarm), .txp_lo_alarm(txp_lo_alarm),
    .bias_hi_alarm(bias_hi_alarm), .bias_max_flag(bias_max_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int first_cyc(input int code);
    int c = (code > 9) ? 9 : code;
    int ns [10] = '{350, 550, 750, 950, 1350, 1550, 1750, 2150, 2950, 3150};
    return (ns[c] + 49) / 50;
  endfunction

  function automatic int rep_cyc(input int code);
    int c = (code > 9) ? 9 : code;
    int ns [10] = '{800, 1200, 1600, 2000, 2800, 3200, 3600, 4400, 6000, 6400};
    return (ns[c] + 49) / 50;
  endfunction

  task automatic short_burst(input int n);
    for (int i = 0; i < n; i++) begin
      rate_code = 4'd9; ben = 1'b1; cyc(5);
      ben = 1'b0; cyc(3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_b;
    int n;
    int prev;
    void'($urandom(32'd4711));
    // R11: reset state
    cyc(3);
    chk("R11 bias in reset", bias_code, 0);
    chk("R11 alarms in reset", {txp_hi_alarm, txp_lo_alarm, bias_hi_alarm, bias_max_flag}, 0);
    chk("R11 ref_sel in reset", ref_sel, 0);
    rst = 1'b0;
    cyc(2);
    chk("R9 initial lookup load", bias_code, 20 << 4);
    exp_b = 20 << 4;

    // R1 / R2: first delay and repeat period, directed and random codes
    for (int i = 0; i < 8; i++) begin
      int code;
      code = (i == 0) ? 0 : (i == 1) ? 9 : (i == 2) ? 15 : int'($urandom % 16);
      rate_code = 4'(code); m_sp = 1'b0; ben = 1'b1;
      prev = bias_code; n = 0;
      do begin cyc(1); n++; end while (bias_code == 13'(prev) && n < 400);
      chk($sformatf("R1 first delay code %0d", code), n, first_cyc(code) + 1);
      chk("R4 raise by one", bias_code, exp_b + 1);
      prev = bias_code; n = 0;
      do begin cyc(1); n++; end while (bias_code == 13'(prev) && n < 400);
      chk($sformatf("R2 repeat period code %0d", code), n, rep_cyc(code));
      ben = 1'b0; exp_b += 2;
      cyc(5);
    end
    chk("R4 code after timing bursts", bias_code, exp_b);

    // R2: enable dropped before first sample
    rate_code = 4'd5; ben = 1'b1; cyc(20); ben = 1'b0; cyc(40);
    chk("R2 aborted sample", bias_code, exp_b);

    // R3 / R5 / R6: full slot cycle
    rate_code = 4'd0; m_sp = 1'b1; ben = 1'b1;
    cyc(8);
    for (int k = 2; k <= 6; k++) cyc(16);
    chk("R4 lower by one x6", bias_code, exp_b - 6);
    chk("R3 slot 6 picks high threshold", ref_sel, 1);
    m_hi = 1'b1; cyc(16);
    chk("R5 high power alarm set", txp_hi_alarm, 1);
    chk("R3 slot 7 bias reference", ref_sel, 3);
    m_bh = 1'b1; cyc(16);
    chk("R6 bias alarm set", bias_hi_alarm, 1);
    chk("R3 wrap to set point", ref_sel, 0);
    m_sp = 1'b0;
    for (int k = 0; k < 6; k++) cyc(16);
    chk("R4 back up", bias_code, exp_b);
    chk("R3 slot 6 picks low threshold", ref_sel, 2);
    m_lo = 1'b0; cyc(16);
    chk("R5 low power alarm set", txp_lo_alarm, 1);
    chk("R5 high alarm held", txp_hi_alarm, 1);
    m_bh = 1'b0; cyc(16);
    chk("R6 bias alarm cleared", bias_hi_alarm, 0);
    ben = 1'b0; m_hi = 1'b0; m_lo = 1'b1; cyc(30);
    chk("R5 alarms frozen while idle", {txp_hi_alarm, txp_lo_alarm}, 3);

    // R8: ceiling
    max_bias = 13'(exp_b + 1); cyc(2);
    chk("R8 flag below ceiling", bias_max_flag, 0);
    ben = 1'b1; cyc(8);
    chk("R8 raise reaches ceiling", bias_code, exp_b + 1);
    chk("R8 flag at ceiling", bias_max_flag, 1);
    cyc(16);
    chk("R8 raise held at ceiling", bias_code, exp_b + 1);
    ben = 1'b0; cyc(2);
    max_bias = 13'(exp_b - 10); cyc(2);
    chk("R8 lowered ceiling clamps", bias_code, exp_b - 10);
    chk("R8 flag after clamp", bias_max_flag, 1);
    max_bias = 13'd8191; cyc(2);
    chk("R8 flag drops", bias_max_flag, 0);
    exp_b -= 10;

    // R7: short-burst run and resume
    lut_bias = 8'd50;
    short_burst(20);
    rate_code = 4'd0; ben = 1'b1; cyc(8); ben = 1'b0; cyc(3);
    exp_b += 1;
    short_burst(31);
    chk("R7 no suspend after 31", bias_code, exp_b);
    short_burst(1);
    chk("R7 suspended loads lookup", bias_code, 50 << 4);
    lut_bias = 8'd60; cyc(2);
    chk("R7 suspended follows lookup", bias_code, 60 << 4);
    max_bias = 13'd1000; lut_bias = 8'd70; cyc(3);
    chk("R9 oversize recall skipped", bias_code, 60 << 4);
    lut_bias = 8'd62; cyc(2);
    chk("R9 fitting recall loads", bias_code, 62 << 4);
    max_bias = 13'd8191;
    rate_code = 4'd0; m_sp = 1'b0; ben = 1'b1; cyc(8);
    chk("R7 resume and step same cycle", bias_code, (62 << 4) + 1);
    ben = 1'b0; lut_bias = 8'd10; cyc(4);
    chk("R7 lookup ignored after resume", bias_code, (62 << 4) + 1);

    // R10: open loop
    open_loop = 1'b1; lut_msb_align = 1'b1; lut_bias = 8'd40; cyc(2);
    chk("R10 msb placement", bias_code, 40 << 5);
    lut_msb_align = 1'b0; cyc(2);
    chk("R10 msb-1 placement", bias_code, 40 << 4);
    max_bias = 13'd5000; lut_msb_align = 1'b1; lut_bias = 8'd255; cyc(2);
    chk("R10 open loop clamp", bias_code, 5000);
    chk("R8 flag in open loop", bias_max_flag, 1);
    m_sp = 1'b1; ben = 1'b1; cyc(8);
    chk("R10 no APC step", bias_code, 5000);
    cyc(16);
    chk("R10 no APC step second", bias_code, 5000);
    ben = 1'b0; cyc(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule